// File: doc/BRIEF.md
# Wavefront control-flow sequencer

This block is the control-flow engine of a SIMD compute unit. It takes one wavefront at a time from a shared pool of ready wavefronts and reads that wavefront's next control-flow instruction. The instruction then passes through four stages: fetch, decode, execute and complete. Each wavefront holds at most one raw instruction word and one decoded instruction. Decode and execute choose among waiting wavefronts in round-robin order.

At execute, a control-flow instruction either finishes locally (no-op or jump) or hands a secondary clause to the arithmetic engine or to the fetch engine. A wavefront that has handed off a clause waits until that engine reports done for its ID. At completion the wavefront ID goes back to the pool. A wavefront is therefore absent from the pool from the moment it is fetched until the moment it completes.

Each wavefront has its own controller with states `WF_IDLE` (in the pool), `WF_FETCH` (read in flight), `WF_BYTES` (raw word held), `WF_READY` (decoded), `WF_CLAUSE` (waiting on an engine) and `WF_DONE` (waiting to complete). Its transitions are:

- `pop`: `WF_IDLE`→`WF_FETCH`
- `capture`: `WF_FETCH`→`WF_BYTES`
- `decode`: `WF_BYTES`→`WF_READY`
- `finish`: `WF_READY`→`WF_DONE`, for a no-op or a jump
- `launch`: `WF_READY`→`WF_CLAUSE`, for an arithmetic or fetch clause
- `clause_done`: `WF_CLAUSE`→`WF_DONE`
- `retire`: `WF_DONE`→`WF_IDLE`

Top module: `wf_cf_seq`

## Requirements
- R1: A no-op whose pop is accepted in cycle c raises `push_valid` for that wavefront in cycle c+4. This follows from the stage order fetch, decode, execute, complete, with one register step per stage plus the memory read.
- R2: `pool_pop` is high exactly when `pool_valid` is high and the offered wavefront is in `WF_IDLE`. In that same cycle `imem_rd_en` is high and `imem_rd_addr` = {wavefront ID, its PC}. The read word is captured from `imem_rd_data` one cycle later.
- R3: Completion pulses `push_valid` for one cycle with the wavefront ID, which returns that wavefront to the pool.
- R4: A wavefront that is not in `WF_IDLE` is not popped again. Offering its ID keeps `pool_pop` low.
- R5: Decode, execute and complete each grant at most one wavefront per cycle. Each stage's pointer moves past the last grant, so wavefronts popped in consecutive cycles complete in the order they were popped.
- R6: The opcode is bits [15:14] of the instruction: 0 = no-op, 1 = jump, 2 = arithmetic clause, 3 = fetch clause. Bits [7:0] are the argument.
- R7: A jump loads the wavefront's PC with the argument, so the next fetch of that wavefront reads that slot.
- R8: An arithmetic-clause instruction pulses `alu_launch` for one cycle with the wavefront ID and the argument as the clause address. The wavefront completes only after `alu_done` names it.
- R9: A fetch-clause instruction pulses `tex_launch` for one cycle with the wavefront ID and the argument as the clause address. The wavefront completes only after `tex_done` names it.
- R10: Every PC resets to 0 and advances by one slot on each fetch of its wavefront.
- R11: A done signal from the engine other than the one the wavefront is waiting on has no effect. No push follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pool_valid | input | 1 | Pool offers a wavefront |
| pool_wf_id | input | 2 | Offered wavefront ID |
| pool_pop | output | 1 | Offered wavefront is taken |
| push_valid | output | 1 | Wavefront returns to the pool |
| push_wf_id | output | 2 | Returning wavefront ID |
| imem_rd_en | output | 1 | Instruction read request |
| imem_rd_addr | output | 10 | {wavefront ID, PC} |
| imem_rd_data | input | 16 | Read word, one cycle after request |
| alu_launch | output | 1 | Start arithmetic clause |
| alu_wf_id | output | 2 | Wavefront of the arithmetic clause |
| alu_addr | output | 8 | Arithmetic clause address |
| alu_done | input | 1 | Arithmetic clause finished |
| alu_done_wf | input | 2 | Wavefront whose arithmetic clause finished |
| tex_launch | output | 1 | Start fetch clause |
| tex_wf_id | output | 2 | Wavefront of the fetch clause |
| tex_addr | output | 8 | Fetch clause address |
| tex_done | input | 1 | Fetch clause finished |
| tex_done_wf | input | 2 | Wavefront whose fetch clause finished |

## Verification
The assertions assume that the pool offers only IDs that are not already in flight, or tolerates `pool_pop` staying low. They also assume that each engine reports done for a wavefront only after launching a clause for it. The stimulus re-offers a busy ID only to check the stall. Each engine is answered one clause at a time, so done never names a wavefront out of turn, except for the deliberate wrong-engine pulse that checks the ignore rule.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [2:0] {
        WF_IDLE, WF_FETCH, WF_BYTES, WF_READY, WF_CLAUSE, WF_DONE
    } wf_state_e;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_JUMP = 2'd1,
        OP_ALU  = 2'd2,
        OP_TEX  = 2'd3
    } cf_op_e;
endpackage

// File: rtl/cfs_rr_arb.sv
module cfs_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] pick;
    logic          found;

    always_comb begin
        gnt   = '0;
        pick  = last_q;
        found = 1'b0;
        for (int i = 1; i <= N; i++) begin
            int idx;
            idx = (int'(last_q) + i) % N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                pick     = IW'(idx);
                gnt[idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= IW'(N - 1);
        else if (found) last_q <= pick;
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R5
    AST_ARB_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (found && $countones(req) > 1) |=> (last_q != $past(pick) || !found || gnt != $past(gnt))); // R5
endmodule

// File: rtl/cfs_wf_ctx.sv
module cfs_wf_ctx
    import cfs_pkg::*;
#(
    parameter int PC_W    = 8,
    parameter int INSTR_W = 16,
    parameter int ARG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_go,
    input  logic               bytes_load,
    input  logic [INSTR_W-1:0] bytes_in,
    input  logic               dec_gnt,
    input  logic               exe_gnt,
    input  logic               cmp_gnt,
    input  logic               alu_done_hit,
    input  logic               tex_done_hit,
    output logic               is_idle,
    output logic               has_bytes,
    output logic               has_instr,
    output logic               is_done,
    output logic [PC_W-1:0]    pc,
    output cf_op_e             op,
    output logic [ARG_W-1:0]   arg
);
    wf_state_e          state_q, state_d;
    logic [INSTR_W-1:0] bytes_q;
    logic               wait_tex_q;
    logic               done_hit;

    assign done_hit = wait_tex_q ? tex_done_hit : alu_done_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WF_IDLE:   if (fetch_go)   state_d = WF_FETCH;
            WF_FETCH:  if (bytes_load) state_d = WF_BYTES;
            WF_BYTES:  if (dec_gnt)    state_d = WF_READY;
            WF_READY:  if (exe_gnt)    state_d = (op == OP_ALU || op == OP_TEX) ? WF_CLAUSE : WF_DONE;
            WF_CLAUSE: if (done_hit)   state_d = WF_DONE;
            WF_DONE:   if (cmp_gnt)    state_d = WF_IDLE;
            default:                   state_d = WF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            bytes_q    <= '0;
            op         <= OP_NOP;
            arg        <= '0;
            wait_tex_q <= 1'b0;
        end else begin
            if (fetch_go && state_q == WF_IDLE) pc <= pc + PC_W'(1);
            if (bytes_load && state_q == WF_FETCH) bytes_q <= bytes_in;
            if (dec_gnt && state_q == WF_BYTES) begin
                op  <= cf_op_e'(bytes_q[INSTR_W-1 -: 2]);
                arg <= bytes_q[ARG_W-1:0];
            end
            if (exe_gnt && state_q == WF_READY) begin
                if (op == OP_JUMP) pc <= arg[PC_W-1:0];
                wait_tex_q <= (op == OP_TEX);
            end
        end
    end

    always_comb begin
        is_idle   = (state_q == WF_IDLE);
        has_bytes = (state_q == WF_BYTES);
        has_instr = (state_q == WF_READY);
        is_done   = (state_q == WF_DONE);
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_go && state_q == WF_IDLE) |=> (pc == $past(pc) + PC_W'(1))); // R10
    AST_CLAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WF_CLAUSE && !done_hit) |=> (state_q == WF_CLAUSE)); // R11
    AST_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WF_IDLE) |=> (state_q != WF_FETCH || $past(state_q) == WF_FETCH)); // R4
endmodule

// File: rtl/wf_cf_seq.sv
module wf_cf_seq
    import cfs_pkg::*;
#(
    parameter int NUM_WF  = 4,
    parameter int PC_W    = 8,
    parameter int INSTR_W = 16,
    parameter int ARG_W   = 8,
    localparam int WF_W   = $clog2(NUM_WF),
    localparam int ADDR_W = WF_W + PC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pool_valid,
    input  logic [WF_W-1:0]    pool_wf_id,
    output logic               pool_pop,
    output logic               push_valid,
    output logic [WF_W-1:0]    push_wf_id,
    output logic               imem_rd_en,
    output logic [ADDR_W-1:0]  imem_rd_addr,
    input  logic [INSTR_W-1:0] imem_rd_data,
    output logic               alu_launch,
    output logic [WF_W-1:0]    alu_wf_id,
    output logic [ARG_W-1:0]   alu_addr,
    input  logic               alu_done,
    input  logic [WF_W-1:0]    alu_done_wf,
    output logic               tex_launch,
    output logic [WF_W-1:0]    tex_wf_id,
    output logic [ARG_W-1:0]   tex_addr,
    input  logic               tex_done,
    input  logic [WF_W-1:0]    tex_done_wf
);
    logic [NUM_WF-1:0] idle_v, bytes_v, instr_v, done_v;
    logic [NUM_WF-1:0] dec_gnt, exe_gnt, cmp_gnt;
    logic [PC_W-1:0]   pc_a  [NUM_WF];
    cf_op_e            op_a  [NUM_WF];
    logic [ARG_W-1:0]  arg_a [NUM_WF];

    logic              fetch_vld_q;
    logic [WF_W-1:0]   fetch_wf_q;

    // fetch: one wavefront per cycle, only if it is idle
    always_comb begin
        pool_pop     = pool_valid && idle_v[pool_wf_id];
        imem_rd_en   = pool_pop;
        imem_rd_addr = {pool_wf_id, pc_a[pool_wf_id]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_vld_q <= 1'b0;
            fetch_wf_q  <= '0;
        end else begin
            fetch_vld_q <= pool_pop;
            fetch_wf_q  <= pool_wf_id;
        end
    end

    generate
        for (genvar g = 0; g < NUM_WF; g++) begin : g_wf
            cfs_wf_ctx #(.PC_W(PC_W), .INSTR_W(INSTR_W), .ARG_W(ARG_W)) u_ctx (
                .clk          (clk),
                .rst_n        (rst_n),
                .fetch_go     (pool_pop && pool_wf_id == WF_W'(g)),
                .bytes_load   (fetch_vld_q && fetch_wf_q == WF_W'(g)),
                .bytes_in     (imem_rd_data),
                .dec_gnt      (dec_gnt[g]),
                .exe_gnt      (exe_gnt[g]),
                .cmp_gnt      (cmp_gnt[g]),
                .alu_done_hit (alu_done && alu_done_wf == WF_W'(g)),
                .tex_done_hit (tex_done && tex_done_wf == WF_W'(g)),
                .is_idle      (idle_v[g]),
                .has_bytes    (bytes_v[g]),
                .has_instr    (instr_v[g]),
                .is_done      (done_v[g]),
                .pc           (pc_a[g]),
                .op           (op_a[g]),
                .arg          (arg_a[g])
            );
        end
    endgenerate

    cfs_rr_arb #(.N(NUM_WF)) u_dec_arb (.clk(clk), .rst_n(rst_n), .req(bytes_v), .gnt(dec_gnt));
    cfs_rr_arb #(.N(NUM_WF)) u_exe_arb (.clk(clk), .rst_n(rst_n), .req(instr_v), .gnt(exe_gnt));
    cfs_rr_arb #(.N(NUM_WF)) u_cmp_arb (.clk(clk), .rst_n(rst_n), .req(done_v),  .gnt(cmp_gnt));

    // execute hand-off and completion outputs
    always_comb begin
        cf_op_e          ex_op;
        logic [ARG_W-1:0] ex_arg;
        logic [WF_W-1:0]  ex_wf;
        ex_op      = OP_NOP;
        ex_arg     = '0;
        ex_wf      = '0;
        push_wf_id = '0;
        for (int i = 0; i < NUM_WF; i++) begin
            if (exe_gnt[i]) begin
                ex_op  = op_a[i];
                ex_arg = arg_a[i];
                ex_wf  = WF_W'(i);
            end
            if (cmp_gnt[i]) push_wf_id = WF_W'(i);
        end
        push_valid = |cmp_gnt;
        alu_launch = (|exe_gnt) && ex_op == OP_ALU;
        tex_launch = (|exe_gnt) && ex_op == OP_TEX;
        alu_wf_id  = ex_wf;
        tex_wf_id  = ex_wf;
        alu_addr   = ex_arg;
        tex_addr   = ex_arg;
    end

    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pool_pop |-> pool_valid); // R2
    AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        !(alu_launch && tex_launch)); // R8
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !(push_valid && push_wf_id == $past(push_wf_id))); // R3
    AST_FETCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        pool_pop |=> !idle_v[$past(pool_wf_id)]); // R2
endmodule

// File: tb/sim_wf_cf_seq.sv
module sim_wf_cf_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pool_valid = 1'b0;
    logic [1:0]  pool_wf_id = '0;
    logic        pool_pop, push_valid, imem_rd_en, alu_launch, tex_launch;
    logic [1:0]  push_wf_id, alu_wf_id, tex_wf_id;
    logic [9:0]  imem_rd_addr;
    logic [15:0] imem_rd_data = '0;
    logic [7:0]  alu_addr, tex_addr;
    logic        alu_done = 1'b0, tex_done = 1'b0;
    logic [1:0]  alu_done_wf = '0, tex_done_wf = '0;

    int checks = 0, failures = 0, cyc = 0;
    logic [25:0] sb_q[$];
    int          exp_cyc [4];
    logic [7:0]  ref_pc  [4];

    always #4 clk = ~clk;

    wf_cf_seq u0 (.*);

    function automatic logic [15:0] prog(input logic [1:0] w, input logic [7:0] p);
        case (p)
            8'd1:    prog = {2'd1, 6'd0, 8'd4};
            8'd4:    prog = {2'd2, 6'd0, 8'h10 + 8'(w)};
            8'd5:    prog = {2'd3, 6'd0, 8'h20 + 8'(w)};
            8'd6:    prog = {2'd1, 6'd0, 8'd0};
            default: prog = 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (imem_rd_en) imem_rd_data <= prog(imem_rd_addr[9:8], imem_rd_addr[7:0]);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: predict events for one issue of wavefront w, then offer it
    task automatic plan(input logic [1:0] w);
        logic [15:0] ins;
        ins = prog(w, ref_pc[w]);
        ref_pc[w] = ref_pc[w] + 8'd1;
        exp_cyc[w] = 0;
        case (ins[15:14])
            2'd1: ref_pc[w] = ins[7:0];                        // R7
            2'd2: sb_q.push_back({2'd1, 8'(w), 16'(ins[7:0])}); // R8
            2'd3: sb_q.push_back({2'd2, 8'(w), 16'(ins[7:0])}); // R9
            default: exp_cyc[w] = cyc + 4;                     // R1
        endcase
        sb_q.push_back({2'd3, 8'(w), 16'd0});
    endtask

    task automatic offer(input logic [1:0] w);
        pool_valid = 1'b1;
        pool_wf_id = w;
        #1;
        check(pool_pop === 1'b1, "R2 pop", 32'(pool_pop), 1);
        check(imem_rd_addr === {w, ref_pc[w]}, "R10 addr", 32'(imem_rd_addr), 32'({w, ref_pc[w]}));
        plan(w);
    endtask

    task automatic issue_one(input logic [1:0] w);
        @(negedge clk);
        offer(w);
        @(negedge clk);
        #1;
        check(pool_pop === 1'b0, "R4 busy stall", 32'(pool_pop), 0);
        pool_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pop expected items and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (alu_launch) begin
                check(sb_q.size() != 0 && sb_q[0] === {2'd1, 8'(alu_wf_id), 16'(alu_addr)},
                      "R8 alu launch", {6'd1, 8'(alu_wf_id), 16'(alu_addr)}, sb_q.size() != 0 ? 32'(sb_q[0]) : 0);
                if (sb_q.size() != 0) void'(sb_q.pop_front());
            end
            if (tex_launch) begin
                check(sb_q.size() != 0 && sb_q[0] === {2'd2, 8'(tex_wf_id), 16'(tex_addr)},
                      "R9 tex launch", {6'd2, 8'(tex_wf_id), 16'(tex_addr)}, sb_q.size() != 0 ? 32'(sb_q[0]) : 0);
                if (sb_q.size() != 0) void'(sb_q.pop_front());
            end
            if (push_valid) begin
                check(sb_q.size() != 0 && sb_q[0] === {2'd3, 8'(push_wf_id), 16'd0},
                      "R3 R5 push order", {6'd3, 8'(push_wf_id), 16'd0}, sb_q.size() != 0 ? 32'(sb_q[0]) : 0);
                if (sb_q.size() != 0) void'(sb_q.pop_front());
                if (exp_cyc[push_wf_id] != 0)
                    check(cyc == exp_cyc[push_wf_id], "R1 latency", cyc, exp_cyc[push_wf_id]);
            end
        end
    end

    // clause engines: wrong-engine done first, then the right one
    initial begin
        forever begin
            @(negedge clk);
            if (alu_launch || tex_launch) begin
                logic       is_alu;
                logic [1:0] w;
                is_alu = alu_launch;
                w = is_alu ? alu_wf_id : tex_wf_id;
                if (is_alu) begin tex_done = 1'b1; tex_done_wf = w; end
                else        begin alu_done = 1'b1; alu_done_wf = w; end
                @(negedge clk);
                tex_done = 1'b0; alu_done = 1'b0;
                if (is_alu) begin tex_done = 1'b1; tex_done_wf = w; end
                else        begin alu_done = 1'b1; alu_done_wf = w; end
                @(negedge clk);
                tex_done = 1'b0; alu_done = 1'b0;
                repeat (2) begin
                    check(push_valid === 1'b0, "R11 wrong done ignored", 32'(push_valid), 0);
                    @(negedge clk);
                end
                if (is_alu) begin alu_done = 1'b1; alu_done_wf = w; end
                else        begin tex_done = 1'b1; tex_done_wf = w; end
                @(negedge clk);
                alu_done = 1'b0; tex_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin ref_pc[i] = 8'd0; exp_cyc[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        check(pool_pop === 1'b0 && push_valid === 1'b0, "R3 reset quiet", 32'({pool_pop, push_valid}), 0);
        check(alu_launch === 1'b0 && tex_launch === 1'b0, "R8 R9 reset quiet", 32'({alu_launch, tex_launch}), 0);
        rst_n = 1'b1;

        // back-to-back no-ops on all wavefronts: round-robin keeps order (R5, R6)
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            offer(2'(w));
        end
        @(negedge clk);
        pool_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);

        // serial walks through jump, arithmetic, fetch clauses and back
        for (int k = 0; k < 6; k++) issue_one(2'd2);
        for (int k = 0; k < 5; k++) issue_one(2'd0);
        issue_one(2'd3);
        issue_one(2'd3);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R3 all returned", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule